// File: doc/BRIEF.md
# Parity-Checked Controlled-Swap Cascade

This block is a combinational model of a reversible cascade made only of controlled-swap gates acting on `P` data lines. Each stage has one control line and two target lines. When the control is 1 the two targets trade values; when it is 0 they pass through. Each stage only moves values between lines, so the number of ones leaving the cascade always equals the number entering it.

A parity line watches the cascade for a single line fault. It starts at 0. Every input line is XORed into it before the first stage, and every output line is XORed into it after the last stage. No other parity logic sits inside the cascade. If the cascade is healthy, the two folds cancel and the parity flag reads 0. If one line is inverted anywhere inside the cascade, the ones count changes by one and the flag reads 1.

A fault-injection port corrupts one line at the boundary after a chosen stage, so detection can be exercised. The gate list comes from three parameter arrays: control, first target and second target. Each array is indexed by stage, and stage 0 acts first. The design is purely combinational, so it has no clock, reset or stream handshake.

Top module: `fsw_parity_cascade`

## Requirements
- R1: A stage whose control line is 1 exchanges the values on its two target lines and leaves every other line unchanged.
- R2: A stage whose control line is 0 passes all lines unchanged.
- R3: With `flt_en` low, `dout` equals the output of the same gate list with no parity logic and no fault, and `par_err` is 0.
- R4: `par_err` equals the XOR of every `din` bit and every `dout` bit. This is the parity line, starting at 0, after the input fold and the output fold.
- R5: With `flt_en` high, `flt_mode` = 0 (invert), an in-range stage and an in-range line, the selected line is inverted and `par_err` is 1 for every `din`.
- R6: `flt_mode` = 1 forces the selected line to 0 and `flt_mode` = 2 forces it to 1. `par_err` is 1 exactly when the forced value differs from the value the line would have carried.
- R7: A fault at stage index `s` acts on the lines after gate `s` has acted and before gate `s+1` acts. Stage 0 is the first gate. A fault at the last stage reaches `dout` directly.
- R8: With `flt_en` low, the values on `flt_stage`, `flt_line` and `flt_mode` have no effect on `dout` or `par_err`.
- R9: A `flt_stage` of `NS` or more, a `flt_line` of `P` or more, or `flt_mode` = 3 leaves `dout` and `par_err` as in the fault-free case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | P | Data lines entering the cascade |
| flt_en | input | 1 | Enables fault injection |
| flt_stage | input | $clog2(NS+1) | Stage after which the fault acts |
| flt_line | input | $clog2(P+1) | Line the fault acts on |
| flt_mode | input | 2 | 0 invert, 1 stuck-at-0, 2 stuck-at-1, 3 none |
| dout | output | P | Data lines leaving the cascade |
| par_err | output | 1 | Parity line result; 1 flags a fault |

## Verification
The bench builds the block with `P` = 8 lines and `NS` = 6 stages. The gate list lets every line serve as a control or a target somewhere, and some stages take as targets lines that earlier stages swapped. With only 256 input vectors, the bench can apply every input against the fault-free cascade and against every inversion and every stuck-at fault at each stage and line. The index widths of 3 and 4 bits leave stage indices 6 and 7 and line indices 8 to 15 unused, so the bench can also drive out-of-range fault selectors and check that they do nothing.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam logic [1:0] FLT_INVERT = 2'd0;
  localparam logic [1:0] FLT_STUCK0 = 2'd1;
  localparam logic [1:0] FLT_STUCK1 = 2'd2;
  localparam logic [1:0] FLT_NONE   = 2'd3;
endpackage

// File: rtl/fsw_swap_gate.sv
module fsw_swap_gate #(
  parameter int P    = 8,
  parameter int CTRL = 0,
  parameter int TA   = 1,
  parameter int TB   = 2
) (
  input  logic [P-1:0] lines_i,
  output logic [P-1:0] lines_o
);
  always_comb begin
    lines_o = lines_i;
    if (lines_i[CTRL]) begin
      lines_o[TA] = lines_i[TB];
      lines_o[TB] = lines_i[TA];
    end
  end
endmodule

// File: rtl/fsw_fault_tap.sv
module fsw_fault_tap #(
  parameter int P  = 8,
  parameter int LW = 4
) (
  input  logic [P-1:0]  lines_i,
  input  logic          hit,
  input  logic [LW-1:0] line_sel,
  input  logic [1:0]    mode,
  output logic [P-1:0]  lines_o
);
  import fsw_pkg::*;
  logic [P-1:0] mask;

  always_comb begin
    mask    = {{(P-1){1'b0}}, 1'b1} << line_sel;
    lines_o = lines_i;
    if (hit) begin
      case (mode)
        FLT_INVERT: lines_o = lines_i ^ mask;
        FLT_STUCK0: lines_o = lines_i & ~mask;
        FLT_STUCK1: lines_o = lines_i | mask;
        default:    lines_o = lines_i;
      endcase
    end
  end
endmodule

// File: rtl/fsw_parity_fold.sv
module fsw_parity_fold #(
  parameter int P = 8
) (
  input  logic         seed,
  input  logic [P-1:0] lines,
  output logic         par_o
);
  logic [P:0] chain;
  assign chain[0] = seed;
  for (genvar k = 0; k < P; k++) begin : g_cnot
    assign chain[k+1] = chain[k] ^ lines[k];
  end
  assign par_o = chain[P];
endmodule

// File: rtl/fsw_parity_cascade.sv
module fsw_parity_cascade #(
  parameter int P  = 8,
  parameter int NS = 6,
  parameter int unsigned GATE_CTRL [NS] = '{0, 3, 6, 1, 2, 4},
  parameter int unsigned GATE_TA   [NS] = '{1, 4, 7, 3, 5, 0},
  parameter int unsigned GATE_TB   [NS] = '{2, 5, 0, 6, 7, 3},
  localparam int SW = $clog2(NS + 1),
  localparam int LW = $clog2(P + 1)
) (
  input  logic [P-1:0]  din,
  input  logic          flt_en,
  input  logic [SW-1:0] flt_stage,
  input  logic [LW-1:0] flt_line,
  input  logic [1:0]    flt_mode,
  output logic [P-1:0]  dout,
  output logic          par_err
);
  logic [P-1:0] stage_in  [NS+1];
  logic [P-1:0] gate_out  [NS];
  logic         par_front;

  assign stage_in[0] = din;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    fsw_swap_gate #(
      .P(P), .CTRL(int'(GATE_CTRL[s])), .TA(int'(GATE_TA[s])), .TB(int'(GATE_TB[s]))
    ) u_gate (
      .lines_i(stage_in[s]),
      .lines_o(gate_out[s])
    );

    fsw_fault_tap #(.P(P), .LW(LW)) u_tap (
      .lines_i (gate_out[s]),
      .hit     (flt_en && (flt_stage == SW'(s))),
      .line_sel(flt_line),
      .mode    (flt_mode),
      .lines_o (stage_in[s+1])
    );
  end

  assign dout = stage_in[NS];

  fsw_parity_fold #(.P(P)) u_fold_in (
    .seed (1'b0),
    .lines(din),
    .par_o(par_front)
  );

  fsw_parity_fold #(.P(P)) u_fold_out (
    .seed (par_front),
    .lines(dout),
    .par_o(par_err)
  );
endmodule

// File: rtl/fsw_parity_cascade_chk.sv
module fsw_parity_cascade_chk #(
  parameter int P  = 8,
  parameter int NS = 6,
  parameter int SW = 3,
  parameter int LW = 4
) (
  input logic [P-1:0]  din,
  input logic          flt_en,
  input logic [SW-1:0] flt_stage,
  input logic [LW-1:0] flt_line,
  input logic [1:0]    flt_mode,
  input logic [P-1:0]  dout,
  input logic          par_err
);
  logic in_range;
  assign in_range = (int'(flt_stage) < NS) && (int'(flt_line) < P);

  always_comb begin
    if (!flt_en) begin
      p_clean_flag_r3: assert (!par_err) else $error("flag raised without fault");
      p_ones_kept_r3: assert ($countones(dout) == $countones(din))
        else $error("ones count changed without fault");
    end
    if (flt_en && in_range && flt_mode == 2'd0) begin
      p_invert_seen_r5: assert (par_err) else $error("inversion not flagged");
    end
    if (flt_en && (!in_range || flt_mode == 2'd3)) begin
      p_inert_select_r9: assert (!par_err) else $error("inert selector flagged");
    end
    p_flag_vs_count_r4: assert (par_err == ($countones(dout) % 2 != $countones(din) % 2))
      else $error("flag disagrees with ones count");
  end
endmodule

bind fsw_parity_cascade fsw_parity_cascade_chk #(.P(P), .NS(NS), .SW(SW), .LW(LW)) u_chk (
  .din(din), .flt_en(flt_en), .flt_stage(flt_stage), .flt_line(flt_line),
  .flt_mode(flt_mode), .dout(dout), .par_err(par_err)
);

// File: tb/fsw_parity_cascade_tb.sv
module fsw_parity_cascade_tb;
  localparam int P  = 8;
  localparam int NS = 6;
  localparam int SW = 3;
  localparam int LW = 4;
  localparam int unsigned CT [NS] = '{0, 3, 6, 1, 2, 4};
  localparam int unsigned TA [NS] = '{1, 4, 7, 3, 5, 0};
  localparam int unsigned TB [NS] = '{2, 5, 0, 6, 7, 3};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [P-1:0]  din;
  logic          flt_en;
  logic [SW-1:0] flt_stage;
  logic [LW-1:0] flt_line;
  logic [1:0]    flt_mode;
  logic [P-1:0]  dout;
  logic          par_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  fsw_parity_cascade #(.P(P), .NS(NS), .GATE_CTRL(CT), .GATE_TA(TA), .GATE_TB(TB)) u_dut (
    .din(din), .flt_en(flt_en), .flt_stage(flt_stage), .flt_line(flt_line),
    .flt_mode(flt_mode), .dout(dout), .par_err(par_err)
  );

  // Behavioural reference: walk the lines as integers, one stage at a time.
  function automatic void model(input int d, input bit en, input int st, input int ln,
                                input int md, output int q, output bit pe);
    int v [P];
    int ones_in = 0, ones_out = 0, tmp;
    for (int k = 0; k < P; k++) begin
      v[k] = (d >> k) & 1;
      ones_in += v[k];
    end
    for (int s = 0; s < NS; s++) begin
      if (v[CT[s]] == 1) begin
        tmp = v[TA[s]]; v[TA[s]] = v[TB[s]]; v[TB[s]] = tmp;
      end
      if (en && st == s && ln < P) begin
        if (md == 0) v[ln] = 1 - v[ln];
        else if (md == 1) v[ln] = 0;
        else if (md == 2) v[ln] = 1;
      end
    end
    q = 0;
    for (int k = 0; k < P; k++) begin
      q |= v[k] << k;
      ones_out += v[k];
    end
    pe = ((ones_in + ones_out) % 2) == 1;
  endfunction

  task automatic apply(input int d, input bit en, input int st, input int ln,
                       input int md, input string tag);
    int q; bit pe;
    @(posedge clk);
    {din, flt_en, flt_stage, flt_line, flt_mode} =
      {P'(d), en, SW'(st), LW'(ln), 2'(md)};
    model(d, en, st, ln, md, q, pe);
    @(negedge clk);
    n_checks++;
    if (dout !== P'(q) || par_err !== pe) begin
      n_fail++;
      $display("FAIL %s din=%h en=%0d st=%0d ln=%0d md=%0d: dout=%h par=%b expected dout=%h par=%b",
               tag, d, en, st, ln, md, dout, par_err, q[P-1:0], pe);
    end
  endtask

  initial begin
    {din, flt_en, flt_stage, flt_line, flt_mode} = '0;
    // R3: idle state, all zero and no fault
    apply(0, 0, 0, 0, 0, "R3");
    // R1: line0 high swaps lines 1 and 2 at the first gate
    apply(8'b0000_0011, 0, 0, 0, 0, "R1");
    // R2: line0 low leaves lines 1 and 2 in place
    apply(8'b0000_0010, 0, 0, 0, 0, "R2");
    // R1,R2,R3,R4: every input, no fault
    for (int d = 0; d < (1 << P); d++) apply(d, 0, 0, 0, 0, "R1,R2,R3,R4");
    // R5,R7: every inversion at every stage and line
    for (int d = 0; d < (1 << P); d++)
      for (int s = 0; s < NS; s++)
        for (int l = 0; l < P; l++) apply(d, 1, s, l, 0, "R5,R7");
    // R6,R7: stuck-at faults
    for (int d = 0; d < (1 << P); d++)
      for (int s = 0; s < NS; s++)
        for (int l = 0; l < P; l++) begin
          apply(d, 1, s, l, 1, "R6,R7");
          apply(d, 1, s, l, 2, "R6,R7");
        end
    // R8: selectors wiggled while disabled
    for (int d = 0; d < (1 << P); d += 7)
      apply(d, 0, d % NS, d % P, d % 3, "R8");
    // R9: out-of-range stage, out-of-range line, inert mode
    for (int d = 0; d < (1 << P); d += 5) begin
      apply(d, 1, NS, 2, 0, "R9");
      apply(d, 1, NS + 1, 4, 2, "R9");
      apply(d, 1, 1, P, 0, "R9");
      apply(d, 1, 3, 15, 1, "R9");
      apply(d, 1, d % NS, d % P, 3, "R9");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule